// File: doc/BRIEF.md
# Low-Side Switch Fault Manager

This block sits between the logic commands for two low-side power channels and their gate drivers. Digital fault flags come in from analog comparators: open-load for channel 1 while it is off, overcurrent for both channels and overtemperature for both channels. From these the block decides whether each gate may be enabled. It drives an active-low status line that reports channel 1 faults. It also raises a disable for the serial bus transmitter while channel 1 is overheated. Every input is asynchronous and passes through a synchronizer. Filter and retry times are parameters counted in clock cycles.

Each fault has its own rule. On channel 1, overcurrent is latched. The latch holds the channel off until the command falls, so software recovers by toggling the command. Open-load is detected only while channel 1 is off. Its indication is held until the command rises. Overtemperature on either channel forces that channel off only for as long as its flag stays high. An overcurrent on channel 2 starts a fixed off time, and the channel resumes by itself at the end of it if it is still commanded. The pins are plain control and status levels. No data flows through the block, so it has no handshake.

Top module: `lsw_fault_mgr`

## Requirements
- R1: During and straight after reset, both gate enables are low, the status line is high and the transmitter disable is low.
- R2: With no fault present, each gate enable follows its own command input after the synchronizer delay.
- R3: An open-load flag sets the status line low only after it has stayed high for at least OL_FILT_CYC consecutive cycles while channel 1 is commanded off. Shorter pulses, and any open-load flag seen while the channel is commanded on, leave the status line high.
- R4: A detected open-load keeps the status line low after the flag clears, until a rising edge of the channel 1 command releases it.
- R5: An overcurrent pulse shorter than OC_FILT_CYC cycles on either channel has no effect on the gate enables or the status line.
- R6: A confirmed overcurrent on channel 1 drives gate 1 and the status line low. Both stay low after the flag clears, for as long as the command stays high.
- R7: A falling edge of the channel 1 command clears a latched overcurrent and sets the status line high again. The next high command turns gate 1 on.
- R8: While the channel 1 overtemperature flag is high, gate 1 is low, the status line is low and the transmitter disable is high. All three recover when the flag clears, with no latching.
- R9: A confirmed overcurrent on channel 2 holds gate 2 low for RETRY_CYC cycles. After that time gate 2 turns on again only if its command is still high.
- R10: While the channel 2 overtemperature flag is high, gate 2 is low. It resumes following its command when the flag clears.
- R11: Faults on channel 2 never change gate 1, the status line or the transmitter disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd1_i | input | 1 | Channel 1 on command |
| cmd2_i | input | 1 | Channel 2 on command |
| ol1_i | input | 1 | Channel 1 open-load comparator flag |
| oc1_i | input | 1 | Channel 1 overcurrent comparator flag |
| ot1_i | input | 1 | Channel 1 overtemperature flag (hysteresis applied upstream) |
| oc2_i | input | 1 | Channel 2 overcurrent comparator flag |
| ot2_i | input | 1 | Channel 2 overtemperature flag (hysteresis applied upstream) |
| gate1_o | output | 1 | Channel 1 gate enable |
| gate2_o | output | 1 | Channel 2 gate enable |
| stat1_n_o | output | 1 | Channel 1 status, low when any channel 1 fault is present or latched |
| txoff_o | output | 1 | Serial bus transmitter disable, high during channel 1 overtemperature |

## Verification
A latch for channel 1 that is set when it should not be appears as a status line stuck low. That shows up within a few cycles of the stimulus that should have released it, whether a command edge or a cleared flag. The same holds for a clear edge with the wrong polarity. A filter that counts wrongly lets short pulses through, or misses faults that persist. This is visible at the gate or status pins about three cycles after the filter window closes. A retry timer of the wrong length or with a stuck reload makes gate 2 return too early, too late or never. This is checked both inside and just after the off window.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  // Bit positions inside the synchronized input vector
  localparam int IDX_CMD1 = 0;
  localparam int IDX_CMD2 = 1;
  localparam int IDX_OL1  = 2;
  localparam int IDX_OC1  = 3;
  localparam int IDX_OT1  = 4;
  localparam int IDX_OC2  = 5;
  localparam int IDX_OT2  = 6;
  localparam int NUM_IN   = 7;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lsw_persist.sv
module lsw_persist #(
  parameter int LIM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic det_o
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIMV = CW'(LIM);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!din_i)         cnt_q <= '0;
    else if (cnt_q != LIMV)  cnt_q <= cnt_q + 1'b1;
  end

  assign det_o = (cnt_q == LIMV);

  // R5
  det_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_o |-> $past(din_i));
endmodule

// File: rtl/lsw_ch1_ctl.sv
module lsw_ch1_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic ol_det_i,
  input  logic oc_det_i,
  input  logic ot_i,
  output logic gate_o,
  output logic stat_n_o,
  output logic txoff_o
);
  logic cmd_d, rise, fall;
  logic ol_lat, oc_lat;
  logic gate_q, stat_q, txoff_q;

  assign rise = cmd_i & ~cmd_d;
  assign fall = ~cmd_i & cmd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d   <= 1'b0;
      ol_lat  <= 1'b0;
      oc_lat  <= 1'b0;
      gate_q  <= 1'b0;
      stat_q  <= 1'b1;
      txoff_q <= 1'b0;
    end else begin
      cmd_d <= cmd_i;
      // open-load: set by confirmed detection, released by command rise
      if (rise)          ol_lat <= 1'b0;
      else if (ol_det_i) ol_lat <= 1'b1;
      // overcurrent: set by confirmed detection, released by command fall
      if (fall)          oc_lat <= 1'b0;
      else if (oc_det_i) oc_lat <= 1'b1;
      gate_q  <= cmd_i & ~oc_lat & ~ot_i;
      stat_q  <= ~(ol_lat | oc_lat | ot_i);
      txoff_q <= ot_i;
    end
  end

  assign gate_o   = gate_q;
  assign stat_n_o = stat_q;
  assign txoff_o  = txoff_q;

  // R6
  oc_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lat |=> (!gate_q && !stat_q));
  // R6
  oc_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat && cmd_i) |=> oc_lat);
  // R4
  ol_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_lat && !cmd_i) |=> (ol_lat && !stat_q));
  // R8
  ot1_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> (!gate_q && !stat_q && txoff_q));
endmodule

// File: rtl/lsw_ch2_ctl.sv
module lsw_ch2_ctl #(
  parameter int RETRY_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic oc_det_i,
  input  logic ot_i,
  output logic gate_o
);
  localparam int TW = $clog2(RETRY_CYC + 1);
  localparam logic [TW-1:0] RETRY_V = TW'(RETRY_CYC);

  logic [TW-1:0] tmr_q;
  logic          gate_q;
  logic          idle;

  assign idle = (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      if (idle && oc_det_i) tmr_q <= RETRY_V;
      else if (!idle)       tmr_q <= tmr_q - 1'b1;
      gate_q <= cmd_i & idle & ~oc_det_i & ~ot_i;
    end
  end

  assign gate_o = gate_q;

  // R9
  retry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> !gate_q);
  // R10
  ot2_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> !gate_q);
endmodule

// File: rtl/lsw_fault_mgr.sv
module lsw_fault_mgr #(
  parameter int SYNC_STAGES = 2,
  parameter int OL_FILT_CYC = 24,
  parameter int OC_FILT_CYC = 4,
  parameter int RETRY_CYC   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd1_i,
  input  logic cmd2_i,
  input  logic ol1_i,
  input  logic oc1_i,
  input  logic ot1_i,
  input  logic oc2_i,
  input  logic ot2_i,
  output logic gate1_o,
  output logic gate2_o,
  output logic stat1_n_o,
  output logic txoff_o
);
  import lsw_pkg::*;

  logic [NUM_IN-1:0] raw, syn;
  logic ol1_det, oc1_det, oc2_det;

  always_comb begin
    raw           = '0;
    raw[IDX_CMD1] = cmd1_i;
    raw[IDX_CMD2] = cmd2_i;
    raw[IDX_OL1]  = ol1_i;
    raw[IDX_OC1]  = oc1_i;
    raw[IDX_OT1]  = ot1_i;
    raw[IDX_OC2]  = oc2_i;
    raw[IDX_OT2]  = ot2_i;
  end

  lsw_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

  // open-load only qualifies while channel 1 is commanded off
  lsw_persist #(.LIM(OL_FILT_CYC)) u_ol1_filt (
    .clk(clk), .rst_n(rst_n),
    .din_i(syn[IDX_OL1] & ~syn[IDX_CMD1]), .det_o(ol1_det));

  lsw_persist #(.LIM(OC_FILT_CYC)) u_oc1_filt (
    .clk(clk), .rst_n(rst_n), .din_i(syn[IDX_OC1]), .det_o(oc1_det));

  lsw_persist #(.LIM(OC_FILT_CYC)) u_oc2_filt (
    .clk(clk), .rst_n(rst_n), .din_i(syn[IDX_OC2]), .det_o(oc2_det));

  lsw_ch1_ctl u_ch1 (
    .clk(clk), .rst_n(rst_n),
    .cmd_i(syn[IDX_CMD1]), .ol_det_i(ol1_det), .oc_det_i(oc1_det),
    .ot_i(syn[IDX_OT1]),
    .gate_o(gate1_o), .stat_n_o(stat1_n_o), .txoff_o(txoff_o));

  lsw_ch2_ctl #(.RETRY_CYC(RETRY_CYC)) u_ch2 (
    .clk(clk), .rst_n(rst_n),
    .cmd_i(syn[IDX_CMD2]), .oc_det_i(oc2_det), .ot_i(syn[IDX_OT2]),
    .gate_o(gate2_o));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!gate1_o && !gate2_o && stat1_n_o && !txoff_o) || rst_n);
endmodule

// File: tb/lsw_fault_mgr_test.sv
module lsw_fault_mgr_test;
  localparam int OLF = 24;
  localparam int OCF = 4;
  localparam int RTY = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd1 = 0, cmd2 = 0, ol1 = 0, oc1 = 0, ot1 = 0, oc2 = 0, ot2 = 0;
  logic gate1, gate2, stat1_n, txoff;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lsw_fault_mgr #(.SYNC_STAGES(2), .OL_FILT_CYC(OLF), .OC_FILT_CYC(OCF),
                  .RETRY_CYC(RTY)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd1_i(cmd1), .cmd2_i(cmd2), .ol1_i(ol1), .oc1_i(oc1), .ot1_i(ot1),
    .oc2_i(oc2), .ot2_i(ot2),
    .gate1_o(gate1), .gate2_o(gate2), .stat1_n_o(stat1_n), .txoff_o(txoff));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_gate(input logic c, input logic t);
    return c & ~t;
  endfunction

  function automatic logic exp_stat(input logic t);
    return ~t;
  endfunction

  initial begin : watchdog
    int k = 0;
    while (!done && k < 100000) begin
      @(posedge clk);
      k++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned r;
    r = $urandom(32'h1a2b);
    cyc(5);
    // R1 reset state
    chk("R1", "gate1", gate1, 1'b0);
    chk("R1", "gate2", gate2, 1'b0);
    chk("R1", "stat1", stat1_n, 1'b1);
    chk("R1", "txoff", txoff, 1'b0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1", "gate1 after release", gate1, 1'b0);
    chk("R1", "stat1 after release", stat1_n, 1'b1);

    // R2 follow commands
    cmd1 = 1; cmd2 = 1; cyc(5);
    chk("R2", "gate1 on", gate1, 1'b1);
    chk("R2", "gate2 on", gate2, 1'b1);
    cmd1 = 0; cyc(5);
    chk("R2", "gate1 off", gate1, 1'b0);
    chk("R2", "gate2 stays", gate2, 1'b1);

    // R3 short open-load pulse while off
    ol1 = 1; cyc(OLF - 4); ol1 = 0; cyc(6);
    chk("R3", "short open-load ignored", stat1_n, 1'b1);
    ol1 = 1; cyc(OLF + 6);
    chk("R3", "open-load detected", stat1_n, 1'b0);
    // R4 held after flag clears
    ol1 = 0; cyc(10);
    chk("R4", "open-load held", stat1_n, 1'b0);
    cmd1 = 1; cyc(5);
    chk("R4", "released by rising edge", stat1_n, 1'b1);
    chk("R4", "gate1 on", gate1, 1'b1);
    // R3 open-load ignored while commanded on
    ol1 = 1; cyc(OLF + 10);
    chk("R3", "open-load while on ignored", stat1_n, 1'b1);
    ol1 = 0; cyc(3);

    // R5 short overcurrent pulse on channel 1
    oc1 = 1; cyc(OCF - 2); oc1 = 0; cyc(6);
    chk("R5", "short oc1 gate", gate1, 1'b1);
    chk("R5", "short oc1 stat", stat1_n, 1'b1);
    // R6 confirmed overcurrent latches
    oc1 = 1; cyc(OCF + 5);
    chk("R6", "oc1 gate off", gate1, 1'b0);
    chk("R6", "oc1 stat low", stat1_n, 1'b0);
    oc1 = 0; cyc(10);
    chk("R6", "oc1 latched gate", gate1, 1'b0);
    chk("R6", "oc1 latched stat", stat1_n, 1'b0);
    // R7 falling edge clears
    cmd1 = 0; cyc(5);
    chk("R7", "stat released", stat1_n, 1'b1);
    chk("R7", "gate still off", gate1, 1'b0);
    cmd1 = 1; cyc(5);
    chk("R7", "gate back on", gate1, 1'b1);

    // R8 overtemperature channel 1
    ot1 = 1; cyc(5);
    chk("R8", "gate1 off", gate1, 1'b0);
    chk("R8", "stat low", stat1_n, 1'b0);
    chk("R8", "txoff high", txoff, 1'b1);
    ot1 = 0; cyc(5);
    chk("R8", "gate1 back", gate1, 1'b1);
    chk("R8", "stat back", stat1_n, 1'b1);
    chk("R8", "txoff back", txoff, 1'b0);

    // R5 short pulse on channel 2
    oc2 = 1; cyc(OCF - 2); oc2 = 0; cyc(6);
    chk("R5", "short oc2 gate", gate2, 1'b1);
    // R9 retry timing, still commanded
    oc2 = 1; cyc(OCF + 6);
    chk("R9", "gate2 off", gate2, 1'b0);
    oc2 = 0; cyc(84);
    chk("R9", "gate2 still off in window", gate2, 1'b0);
    chk("R11", "gate1 unaffected", gate1, 1'b1);
    chk("R11", "stat1 unaffected", stat1_n, 1'b1);
    chk("R11", "txoff unaffected", txoff, 1'b0);
    cyc(25);
    chk("R9", "gate2 resumed", gate2, 1'b1);
    // R9 no resume when command dropped
    oc2 = 1; cyc(OCF + 6); oc2 = 0; cmd2 = 0; cyc(RTY + 20);
    chk("R9", "gate2 stays off uncommanded", gate2, 1'b0);
    cmd2 = 1; cyc(5);
    chk("R9", "gate2 on after recommand", gate2, 1'b1);

    // R10 overtemperature channel 2
    ot2 = 1; cyc(5);
    chk("R10", "gate2 off", gate2, 1'b0);
    chk("R11", "stat1 unaffected by ot2", stat1_n, 1'b1);
    ot2 = 0; cyc(5);
    chk("R10", "gate2 back", gate2, 1'b1);

    // R2 R8 R10 random levels of commands and temperature flags
    for (int i = 0; i < 60; i++) begin
      cmd1 = 1'($urandom); cmd2 = 1'($urandom);
      ot1  = ($urandom % 4) == 0; ot2 = ($urandom % 4) == 0;
      cyc(6 + ($urandom % 8));
      chk("R2", "rand gate1", gate1, exp_gate(cmd1, ot1));
      chk("R10", "rand gate2", gate2, exp_gate(cmd2, ot2));
      chk("R8", "rand stat1", stat1_n, exp_stat(ot1));
      chk("R8", "rand txoff", txoff, ot1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule